// File: doc/BRIEF.md
# Pulse-Skipping PWM with Current Trip

This block drives the gate of the switch in a switching regulator. A free-running sawtooth counter defines fixed-length frames, and in every frame that carries a pulse the gate is high while the counter is below a duty value. Whether a frame carries a pulse depends on a voltage-sense comparator bit, sampled at the end of the previous frame. If the bit is low, the output has sagged and a pulse is issued. If the bit is high, the frame is skipped. A separate current-sense comparator bit ends the running pulse early. Once it trips, the gate stays low until the frame ends.

The duty word is latched only at a boundary that opens a pulsing frame. It can therefore be written once and left alone, and a write in the middle of a frame never changes the pulse in progress. Each pulsing frame starts with a one-cycle strobe. The all-ones duty value is a special case. It holds the gate permanently high and bypasses both the voltage gating and the current trip.

Top module: `pwm_skip_trip`

## Requirements
- R1: A frame lasts `frame_last`+1 clocks, where `frame_last` is the final count value. In a pulsing frame, the gate is high in clock k of the frame (k counted from 0) exactly when k < the latched duty. The gate is therefore high for min(duty, `frame_last`+1) clocks.
- R2: The synchronized `volt_hi` value is sampled on the final clock of each frame. A low sample makes the next frame a pulsing frame.
- R3: A high `volt_hi` sample makes the next frame a skipped frame. In a skipped frame the gate stays low and `frame_done` does not pulse.
- R4: `duty` is captured only at a boundary that starts a pulsing frame. A change to `duty` in the middle of a frame has no effect on that frame's pulse. With no further writes, the captured value is reused in every following pulsing frame.
- R5: `frame_done` is high for exactly the first clock of every pulsing frame and is low otherwise.
- R6: Once the synchronized `over_cur` is seen high, the gate is low in that clock and in every remaining clock of the frame.
- R7: The current trip clears at the frame boundary. A frame that follows a tripped frame delivers its full pulse unless `over_cur` is high again.
- R8: When `duty` equals 16'hFFFF, the gate is high from the next clock onward, whatever the state of `volt_hi` and `over_cur`.
- R9: `volt_hi` and `over_cur` each pass through two flip-flops. A change on either pin acts on the logic two clocks later.
- R10: While `rst` is high, and after it is released, `gate` and `frame_done` are low. The first frame after reset is a skipped frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty | input | 16 | Duty word; 16'hFFFF forces the gate high |
| frame_last | input | 16 | Final count value of a frame (frame length minus one) |
| volt_hi | input | 1 | Voltage comparator; high means the output is at or above target |
| over_cur | input | 1 | Current comparator; high means over-current |
| gate | output | 1 | Switch drive |
| frame_done | output | 1 | One-clock strobe at the start of each pulsing frame |

## Verification
The duty value is swept across every setting from zero to past the frame length, for two frame lengths, with the voltage bit held low. This separates correct compare edges from off-by-one pulse widths and shows clamping at the frame length. Holding the voltage bit high shows whether frames are really skipped and strobes withheld. A single-clock current pulse at a known position in the frame shows both the two-clock synchronizer delay and the trip latch, and a long current pulse shows that no pulse is delivered while it lasts. A duty write in the middle of a frame, the all-ones duty value under adverse comparator inputs, and the return to normal duty afterwards separate the boundary capture from any path that uses the duty word directly.

// File: rtl/pwm_skip_pkg.sv
package pwm_skip_pkg;

    typedef enum logic [0:0] {
        FR_SKIP  = 1'b0,
        FR_PULSE = 1'b1
    } frame_mode_t;

    typedef struct packed {
        logic volt_hi;
        logic over_cur;
    } sense_t;

    function automatic logic all_ones16(input logic [15:0] v);
        return &v;
    endfunction

endpackage

// File: rtl/pwm_sync2.sv
module pwm_sync2 #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= '0;
        else     stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= '0;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];

    // R9: output follows the raw input two clocks later
    assert_sync_delay_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (q == $past(d, 2)));
endmodule

// File: rtl/pwm_frame_ctrl.sv
module pwm_frame_ctrl
    import pwm_skip_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DUTY_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  frame_last,
    input  logic [DUTY_W-1:0] duty_in,
    input  logic              volt_hi_s,
    output logic [CNT_W-1:0]  cnt_o,
    output frame_mode_t       mode_o,
    output logic [DUTY_W-1:0] duty_o,
    output logic              done_o,
    output logic              frame_end_o
);
    logic [CNT_W-1:0]  cnt_q;
    frame_mode_t       mode_q;
    logic [DUTY_W-1:0] duty_q;
    logic              done_q;
    logic              frame_end;

    assign frame_end = (cnt_q >= frame_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            mode_q <= FR_SKIP;
            duty_q <= '0;
            done_q <= 1'b0;
        end else if (frame_end) begin
            cnt_q <= '0;
            if (!volt_hi_s) begin
                mode_q <= FR_PULSE;
                duty_q <= duty_in;
                done_q <= 1'b1;
            end else begin
                mode_q <= FR_SKIP;
                done_q <= 1'b0;
            end
        end else begin
            cnt_q  <= cnt_q + 1'b1;
            done_q <= 1'b0;
        end
    end

    assign cnt_o       = cnt_q;
    assign mode_o      = mode_q;
    assign duty_o      = duty_q;
    assign done_o      = done_q;
    assign frame_end_o = frame_end;

    // R2: low sample at the last clock opens a pulsing frame with fresh duty
    assert_pulse_open_R2: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !volt_hi_s) |=> (done_o && mode_o == FR_PULSE && duty_o == $past(duty_in)));
    // R3: high sample gives a skipped frame with no strobe
    assert_skip_frame_R3: assert property (@(posedge clk) disable iff (rst)
        (frame_end && volt_hi_s) |=> (!done_o && mode_o == FR_SKIP));
    // R4: duty stays put away from frame boundaries
    assert_duty_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> $stable(duty_o));
    // R5: strobe only in the first clock of a frame
    assert_done_first_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (cnt_o == '0));
endmodule

// File: rtl/pwm_trip_gate.sv
module pwm_trip_gate
    import pwm_skip_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DUTY_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_end,
    input  logic              over_cur_s,
    input  frame_mode_t       mode,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [DUTY_W-1:0] duty_q,
    input  logic [DUTY_W-1:0] duty_in,
    output logic              gate_o
);
    localparam int CMP_W = (CNT_W > DUTY_W) ? CNT_W : DUTY_W;

    logic trip_q;
    logic full_q;
    logic below;

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_q <= 1'b0;
            full_q <= 1'b0;
        end else begin
            full_q <= &duty_in;
            if (frame_end) trip_q <= 1'b0;
            else           trip_q <= trip_q | over_cur_s;
        end
    end

    assign below  = CMP_W'(cnt) < CMP_W'(duty_q);
    assign gate_o = full_q |
                    ((mode == FR_PULSE) & below & ~trip_q & ~over_cur_s);

    // R6: a trip seen mid-frame keeps the gate low next clock
    assert_trip_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (over_cur_s && !frame_end && !(&duty_in)) |=> !gate_o);
    // R8: all-ones duty drives the gate high on the following clock
    assert_full_high_R8: assert property (@(posedge clk) disable iff (rst)
        (&duty_in) |=> gate_o);
    // R10: reset leaves the gate low
    assert_reset_low_R10: assert property (@(posedge clk)
        rst |=> !gate_o);
endmodule

// File: rtl/pwm_skip_trip.sv
module pwm_skip_trip
    import pwm_skip_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DUTY_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty,
    input  logic [CNT_W-1:0]  frame_last,
    input  logic              volt_hi,
    input  logic              over_cur,
    output logic              gate,
    output logic              frame_done
);
    sense_t            raw, synced;
    logic [CNT_W-1:0]  cnt;
    frame_mode_t       mode;
    logic [DUTY_W-1:0] duty_q;
    logic              frame_end;

    assign raw.volt_hi  = volt_hi;
    assign raw.over_cur = over_cur;

    pwm_sync2 #(.WIDTH($bits(sense_t)), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    pwm_frame_ctrl #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .frame_last  (frame_last),
        .duty_in     (duty),
        .volt_hi_s   (synced.volt_hi),
        .cnt_o       (cnt),
        .mode_o      (mode),
        .duty_o      (duty_q),
        .done_o      (frame_done),
        .frame_end_o (frame_end)
    );

    pwm_trip_gate #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_gate (
        .clk        (clk),
        .rst        (rst),
        .frame_end  (frame_end),
        .over_cur_s (synced.over_cur),
        .mode       (mode),
        .cnt        (cnt),
        .duty_q     (duty_q),
        .duty_in    (duty),
        .gate_o     (gate)
    );
endmodule

// File: tb/pwm_skip_trip_bench.sv
module pwm_skip_trip_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] duty = 16'd0;
    logic [15:0] frame_last = 16'd7;
    logic        volt_hi = 1'b1;
    logic        over_cur = 1'b0;
    logic        gate;
    logic        frame_done;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    pwm_skip_trip u_pwm_skip_trip (
        .clk        (clk),
        .rst        (rst),
        .duty       (duty),
        .frame_last (frame_last),
        .volt_hi    (volt_hi),
        .over_cur   (over_cur),
        .gate       (gate),
        .frame_done (frame_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // Returns at the falling edge inside the first clock of a pulsing frame
    task automatic wait_done(input string req);
        int n = 0;
        @(negedge clk);
        while (frame_done !== 1'b1 && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (n >= 200) check(req, 0, 1);
    endtask

    // Counts gate-high clocks and strobes over n clocks, starting with the current one
    task automatic measure(input int n, output int highs, output int dones);
        highs = 0;
        dones = 0;
        for (int i = 0; i < n; i++) begin
            highs += int'(gate);
            dones += int'(frame_done);
            @(negedge clk);
        end
    endtask

    function automatic int expect_width(input int d, input int len);
        return (d < len) ? d : len;
    endfunction

    initial begin
        int h, d, len;
        // R10: reset state
        repeat (4) @(negedge clk);
        check("R10 gate in reset", int'(gate), 0);
        check("R10 done in reset", int'(frame_done), 0);
        duty = 16'd6;
        rst = 1'b0;
        measure(8, h, d);
        check("R10 first frame skipped gate", h, 0);
        check("R10 first frame no done", d, 0);

        // R1/R2: sweep duty over two frame lengths with A low
        volt_hi = 1'b0;
        for (int fl = 3; fl <= 7; fl += 4) begin
            frame_last = 16'(fl);
            for (int dv = 0; dv <= fl + 2; dv++) begin
                duty = 16'(dv);
                wait_done("R2 pulse frame start");
                wait_done("R2 pulse frame start");
                len = fl + 1;
                measure(len, h, d);
                check($sformatf("R1 width fl=%0d duty=%0d", fl, dv), h, expect_width(dv, len));
            end
        end

        // R5: one strobe per pulsing frame, steady duty reused (R4)
        frame_last = 16'd7;
        duty = 16'd6;
        wait_done("R5 sync");
        wait_done("R5 sync");
        measure(24, h, d);
        check("R5 strobes over three frames", d, 3);
        check("R4 duty reused with no writes", h, 18);

        // R4: mid-frame duty write does not affect current frame
        wait_done("R4 sync");
        duty = 16'd2;
        measure(8, h, d);
        check("R4 current frame keeps old duty", h, 6);
        measure(8, h, d);
        check("R4 next frame uses new duty", h, 2);

        // R3: A high skips frames
        duty = 16'd6;
        volt_hi = 1'b1;
        repeat (20) @(negedge clk);
        measure(24, h, d);
        check("R3 skipped frames gate", h, 0);
        check("R3 skipped frames strobe", d, 0);
        volt_hi = 1'b0;
        wait_done("R2 resume");
        measure(8, h, d);
        check("R2 pulsing resumes", h, 6);

        // R6/R9: one-clock B pulse in clock 0 takes effect in clock 2
        wait_done("R6 sync");
        h = int'(gate);
        over_cur = 1'b1;
        @(negedge clk);
        h += int'(gate);
        over_cur = 1'b0;
        for (int i = 2; i < 8; i++) begin
            @(negedge clk);
            h += int'(gate);
        end
        check("R6 R9 tripped frame width", h, 2);
        @(negedge clk);
        check("R7 next frame strobe", int'(frame_done), 1);
        measure(8, h, d);
        check("R7 next frame full width", h, 6);

        // R6: B held high across a full frame gives no pulse
        over_cur = 1'b1;
        repeat (3) @(negedge clk);
        wait_done("R6 hold sync");
        measure(8, h, d);
        check("R6 held trip width", h, 0);
        over_cur = 1'b0;
        wait_done("R7 release");
        wait_done("R7 release");
        measure(8, h, d);
        check("R7 width after release", h, 6);

        // R8: full scale ignores A and B
        duty = 16'hFFFF;
        volt_hi = 1'b1;
        @(negedge clk);
        check("R8 high one clock after", int'(gate), 1);
        repeat (4) @(negedge clk);
        measure(20, h, d);
        check("R8 full scale with A high", h, 20);
        over_cur = 1'b1;
        repeat (3) @(negedge clk);
        measure(20, h, d);
        check("R8 full scale with B high", h, 20);
        over_cur = 1'b0;
        volt_hi = 1'b0;
        duty = 16'd5;
        repeat (3) @(negedge clk);
        wait_done("R8 exit");
        measure(8, h, d);
        check("R8 back to normal duty", h, 5);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule